// File: doc/BRIEF.md
# Eight-bit single-cycle mini processor

This block is a compact processor core for an eight-bit instruction set. Each instruction is one byte wide. The core holds four eight-bit general registers, an eight-bit program counter, and two condition flags: zero and negative. Code and data live in two separate 256-byte arrays inside the block. Each instruction is fetched, decoded and retired in a single clock period. All architectural state changes on the falling clock edge.

The memories are filled through a load port. While the load enable is high, the core is frozen and one byte per falling edge goes into the selected array. When the enable drops, the core runs one instruction per falling edge, starting from the program counter. A register peek port, a data-memory peek at the load address, and the program counter and flag outputs show the architectural state from outside the block.

Top module: `mini8_core`

## Requirements
- R1: After reset the program counter reads 0x80, both flags read 0 and all four registers read 0.
- R2: The opcode sits in instruction bits [3:0]. OpA is bits [7:6] and OpB is bits [5:4]. Code 0100 writes OpA+OpB into OpA, 0110 writes OpA-OpB and 1000 writes the bitwise NAND. Each sets Z when the 8-bit result is zero and sets N to result bit 7.
- R3: Any code with bits [2:0]=111 ORs the zero-extended bits [7:3] into register 1 and sets Z and N from the result.
- R4: Any code with bits [2:0]=011 shifts OpA by the amount in bits [4:3]. It shifts left when bit 5 is 1 and logically right when bit 5 is 0. The flags are left unchanged.
- R5: Code 0000 loads OpA from the data byte addressed by OpB. Code 0010 stores OpA to the data byte addressed by OpB. Neither changes the flags.
- R6: Codes 0101, 1001 and 1101 branch when Z=1, Z=0 and N=0 respectively. A taken branch sets PC = PC + 1 + sign-extended bits [7:4]. A branch that is not taken sets PC = PC + 1. Branches change no register and no flag.
- R7: The codes 0001, 1010, 1100 and 1110 change nothing except PC = PC + 1.
- R8: Each instruction retires on one falling edge. The program counter advances modulo 256.
- R9: While the load enable is high, the core state holds. Each falling edge writes the load data into the code array (select high) or the data array (select low) at the load address.
- R10: An instruction never reads and writes the data array in the same cycle. A stored byte is seen by a later load and by the data peek.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_en | input | 1 | Freeze the core and write one load byte per falling edge |
| ld_code | input | 1 | Load target: 1 = code array, 0 = data array |
| ld_addr | input | 8 | Load address, also the data peek address |
| ld_data | input | 8 | Load byte |
| peek_sel | input | 2 | Register index to observe |
| peek_val | output | 8 | Contents of the selected register |
| dm_peek | output | 8 | Data array byte at ld_addr |
| pc | output | 8 | Program counter |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
The hardest cases to reach are those that depend on state built up over many instructions. Examples are a conditional branch decided by flags from an earlier arithmetic result, a load from an address that an earlier store just wrote, and a branch that wraps the counter past 0xFF. The bench reaches them without a fixed program: before every step it writes the next instruction byte at the current program counter. It then sweeps all 256 instruction bytes in four distinct permuted orders. The registers, flags, data and counter drift through many values, and a reference model in the bench tracks every step.

// File: rtl/mini8_pkg.sv
`timescale 1ns/1ps
package mini8_pkg;
  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_OR, ALU_NAND, ALU_SHF
  } alu_op_e;

  typedef enum logic [1:0] {
    BR_NONE, BR_ZSET, BR_ZCLR, BR_NCLR
  } br_kind_e;

  typedef struct packed {
    logic     rf_we;
    logic     wb_mem;
    logic     dst_r1;
    logic     flag_we;
    logic     mem_rd;
    logic     mem_wr;
    alu_op_e  alu_op;
    br_kind_e br;
  } ctrl_t;
endpackage

// File: rtl/mini8_decode.sv
`timescale 1ns/1ps
module mini8_decode
  import mini8_pkg::*;
(
  input  logic [3:0] opc,
  output ctrl_t      ctl
);
  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    ctl.br     = BR_NONE;
    casez (opc)
      4'b0000: begin ctl.rf_we = 1'b1; ctl.wb_mem = 1'b1; ctl.mem_rd = 1'b1; end
      4'b0010: ctl.mem_wr = 1'b1;
      4'b0100: begin ctl.rf_we = 1'b1; ctl.flag_we = 1'b1; ctl.alu_op = ALU_ADD; end
      4'b0110: begin ctl.rf_we = 1'b1; ctl.flag_we = 1'b1; ctl.alu_op = ALU_SUB; end
      4'b1000: begin ctl.rf_we = 1'b1; ctl.flag_we = 1'b1; ctl.alu_op = ALU_NAND; end
      4'b?111: begin
        ctl.rf_we = 1'b1; ctl.flag_we = 1'b1; ctl.dst_r1 = 1'b1; ctl.alu_op = ALU_OR;
      end
      4'b?011: begin ctl.rf_we = 1'b1; ctl.alu_op = ALU_SHF; end
      4'b0101: ctl.br = BR_ZSET;
      4'b1001: ctl.br = BR_ZCLR;
      4'b1101: ctl.br = BR_NCLR;
      default: ;
    endcase
  end

  // R10
  mem_rw_excl_chk: assert final (!(ctl.mem_rd && ctl.mem_wr));
endmodule

// File: rtl/mini8_alu.sv
`timescale 1ns/1ps
module mini8_alu
  import mini8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         neg
);
  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_OR:   y = a | b;
      ALU_NAND: y = ~(a & b);
      ALU_SHF:  y = b[2] ? (a << b[1:0]) : (a >> b[1:0]);
      default:  y = a;
    endcase
  end

  assign zero = (y == '0);
  assign neg  = y[W-1];
endmodule

// File: rtl/mini8_regfile.sv
`timescale 1ns/1ps
module mini8_regfile #(
  parameter int W    = 8,
  parameter int N    = 4,
  localparam int IW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra,
  input  logic [IW-1:0] rb,
  input  logic [IW-1:0] rp,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_p
);
  logic [N-1:0][W-1:0] regs_q, regs_d;

  always_comb begin
    regs_d = regs_q;
    if (we) regs_d[waddr] = wdata;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign rd_a = regs_q[ra];
  assign rd_b = regs_q[rb];
  assign rd_p = regs_q[rp];

  // R2
  rf_write_chk: assert property (@(negedge clk) disable iff (!rst_n)
    we |=> regs_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/mini8_core.sv
`timescale 1ns/1ps
module mini8_core
  import mini8_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter int              ADDR_W   = 8,
  parameter int              NREG     = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = 8'h80,
  localparam int             DEPTH    = 1 << ADDR_W,
  localparam int             RIDX_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              ld_code,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [RIDX_W-1:0] peek_sel,
  output logic [DATA_W-1:0] peek_val,
  output logic [DATA_W-1:0] dm_peek,
  output logic [ADDR_W-1:0] pc,
  output logic              flag_z,
  output logic              flag_n
);
  // reset: asserted at once, released after two falling edges
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic run;
  assign run = rst_s && !ld_en;

  logic [DATA_W-1:0] imem [DEPTH];
  logic [DATA_W-1:0] dmem [DEPTH];

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              z_q, n_q, z_d, n_d;
  logic [7:0]        instr;
  ctrl_t             ctl;

  assign instr = imem[pc_q];

  mini8_decode u_dec (.opc(instr[3:0]), .ctl(ctl));

  logic [RIDX_W-1:0] ra, rb;
  logic [DATA_W-1:0] rd_a, rd_b, alu_b, alu_y, wdata, dm_rd;
  logic              alu_zero, alu_neg, rf_we, br_take;
  logic [ADDR_W-1:0] br_off;

  assign ra = ctl.dst_r1 ? RIDX_W'(1) : RIDX_W'(instr[7:6]);
  assign rb = RIDX_W'(instr[5:4]);

  always_comb begin
    unique case (ctl.alu_op)
      ALU_OR:  alu_b = {{(DATA_W-5){1'b0}}, instr[7:3]};
      ALU_SHF: alu_b = {{(DATA_W-3){1'b0}}, instr[5:3]};
      default: alu_b = rd_b;
    endcase
  end

  mini8_alu #(.W(DATA_W)) u_alu (
    .a(rd_a), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero), .neg(alu_neg)
  );

  assign dm_rd = ctl.mem_rd ? dmem[ADDR_W'(rd_b)] : '0;
  assign wdata = ctl.wb_mem ? dm_rd : alu_y;
  assign rf_we = run && ctl.rf_we;

  mini8_regfile #(.W(DATA_W), .N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_s), .we(rf_we), .waddr(ra), .wdata(wdata),
    .ra(ra), .rb(rb), .rp(peek_sel), .rd_a(rd_a), .rd_b(rd_b), .rd_p(peek_val)
  );

  always_comb begin
    unique case (ctl.br)
      BR_ZSET: br_take = z_q;
      BR_ZCLR: br_take = !z_q;
      BR_NCLR: br_take = !n_q;
      default: br_take = 1'b0;
    endcase
  end

  assign br_off = br_take ? {{(ADDR_W-4){instr[7]}}, instr[7:4]} : '0;
  assign pc_d   = pc_q + 1'b1 + br_off;
  assign z_d    = ctl.flag_we ? alu_zero : z_q;
  assign n_d    = ctl.flag_we ? alu_neg  : n_q;

  always_ff @(negedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pc_q <= RESET_PC;
      z_q  <= 1'b0;
      n_q  <= 1'b0;
    end else if (run) begin
      pc_q <= pc_d;
      z_q  <= z_d;
      n_q  <= n_d;
    end
  end

  always_ff @(negedge clk) begin
    if (ld_en && ld_code) imem[ld_addr] <= ld_data;
  end

  always_ff @(negedge clk) begin
    if (ld_en && !ld_code)        dmem[ld_addr] <= ld_data;
    else if (run && ctl.mem_wr)   dmem[ADDR_W'(rd_b)] <= rd_a;
  end

  assign dm_peek = dmem[ld_addr];
  assign pc      = pc_q;
  assign flag_z  = z_q;
  assign flag_n  = n_q;

  // R8
  pc_step_chk: assert property (@(negedge clk) disable iff (!rst_s)
    run && !br_take |=> pc_q == $past(pc_q) + 1'b1);
  // R9
  pc_hold_chk: assert property (@(negedge clk) disable iff (!rst_s)
    ld_en |=> $stable(pc_q) && $stable({z_q, n_q}));
  // R4
  flag_keep_chk: assert property (@(negedge clk) disable iff (!rst_s)
    run && !ctl.flag_we |=> $stable({z_q, n_q}));
  // R6
  br_no_write_chk: assert property (@(negedge clk) disable iff (!rst_s)
    ctl.br != BR_NONE |-> !ctl.rf_we && !ctl.mem_wr && !ctl.flag_we);
endmodule

// File: tb/mini8_core_bench.sv
`timescale 1ns/1ps
module mini8_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_en = 1'b1;
  logic       ld_code = 1'b0;
  logic [7:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [1:0] peek_sel = '0;
  logic [7:0] peek_val, dm_peek, pc;
  logic       flag_z, flag_n;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_rf [4];
  logic [7:0] m_dm [256];
  logic [7:0] m_pc;
  logic       m_z, m_n;

  always #4 clk = ~clk;

  mini8_core u_mini8_core (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_code(ld_code), .ld_addr(ld_addr),
    .ld_data(ld_data), .peek_sel(peek_sel), .peek_val(peek_val), .dm_peek(dm_peek),
    .pc(pc), .flag_z(flag_z), .flag_n(flag_n)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [7:0] ins);
    casez (ins[3:0])
      4'b0100, 4'b0110, 4'b1000: return "R2";
      4'b?111:                   return "R3";
      4'b?011:                   return "R4";
      4'b0000, 4'b0010:          return "R5";
      4'b0101, 4'b1001, 4'b1101: return "R6";
      default:                   return "R7";
    endcase
  endfunction

  task automatic read_regs(output logic [31:0] v);
    for (int i = 0; i < 4; i++) begin
      peek_sel = 2'(i);
      #0.2;
      v[i*8 +: 8] = peek_val;
    end
  endtask

  task automatic load_byte(input logic code, input logic [7:0] a, input logic [7:0] d);
    ld_code = code; ld_addr = a; ld_data = d;
    @(posedge clk); #1;
  endtask

  task automatic run_one();
    ld_en = 1'b0;
    @(posedge clk); #1;
    ld_en = 1'b1;
  endtask

  task automatic model_step(input logic [7:0] ins);
    logic [1:0] a, b;
    logic [7:0] r;
    logic       fl, take;
    a = ins[7:6]; b = ins[5:4]; r = '0; fl = 1'b0; take = 1'b0;
    casez (ins[3:0])
      4'b0000: m_rf[a] = m_dm[m_rf[b]];
      4'b0010: m_dm[m_rf[b]] = m_rf[a];
      4'b0100: begin r = m_rf[a] + m_rf[b]; m_rf[a] = r; fl = 1'b1; end
      4'b0110: begin r = m_rf[a] - m_rf[b]; m_rf[a] = r; fl = 1'b1; end
      4'b1000: begin r = ~(m_rf[a] & m_rf[b]); m_rf[a] = r; fl = 1'b1; end
      4'b?111: begin r = m_rf[1] | {3'b000, ins[7:3]}; m_rf[1] = r; fl = 1'b1; end
      4'b?011: m_rf[a] = ins[5] ? (m_rf[a] << ins[4:3]) : (m_rf[a] >> ins[4:3]);
      4'b0101: take = m_z;
      4'b1001: take = !m_z;
      4'b1101: take = !m_n;
      default: ;
    endcase
    if (fl) begin m_z = (r == 8'h00); m_n = r[7]; end
    m_pc = m_pc + 8'd1 + (take ? {{4{ins[7]}}, ins[7:4]} : 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] regs;
    logic [7:0]  ins, pc0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    read_regs(regs);
    chk("R1", "pc", 32'(pc), 32'h80);
    chk("R1", "flags", {30'd0, flag_z, flag_n}, 32'd0);
    chk("R1", "regs", regs, 32'd0);
    m_pc = 8'h80; m_z = 1'b0; m_n = 1'b0;
    for (int i = 0; i < 4; i++) m_rf[i] = 8'h00;

    // R9 fill data array through the load port and read it back
    for (int i = 0; i < 256; i++) begin
      m_dm[i] = 8'(i * 37 + 11);
      load_byte(1'b0, 8'(i), m_dm[i]);
    end
    ld_addr = 8'h5a; #0.2;
    chk("R9", "data load readback", 32'(dm_peek), 32'(8'(8'h5a * 37 + 11)));
    chk("R9", "pc held during load", 32'(pc), 32'h80);

    // sweep: every instruction byte in four permuted orders
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) begin
        ins = 8'(i * (2 * p + 73) + p * 17);
        load_byte(1'b1, m_pc, ins);
        pc0 = m_pc;
        run_one();
        model_step(ins);
        read_regs(regs);
        chk((ins[3:0] inside {4'b0101, 4'b1001, 4'b1101}) ? "R6" : "R8", "pc",
            32'(pc), 32'(m_pc));
        chk(req_of(ins), "regs", regs, {m_rf[3], m_rf[2], m_rf[1], m_rf[0]});
        chk(req_of(ins), "flags", {30'd0, flag_z, flag_n}, {30'd0, m_z, m_n});
        if (pc0 == 8'hff && !(ins[3:0] inside {4'b0101, 4'b1001, 4'b1101}))
          chk("R8", "pc wrap", 32'(pc), 32'h00);
      end
    end

    // R9 hold while load enable stays high
    pc0 = pc;
    repeat (5) @(posedge clk);
    #1;
    chk("R9", "pc hold", 32'(pc), 32'(pc0));
    chk("R9", "flags hold", {30'd0, flag_z, flag_n}, {30'd0, m_z, m_n});

    // R10 stored bytes visible in the data array
    for (int i = 0; i < 256; i++) begin
      ld_addr = 8'(i); #0.01;
      chk("R10", "data array", 32'(dm_peek), 32'(m_dm[i]));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule